// File: doc/BRIEF.md
# SPI Controller Interrupt and Soft-Reset Wrapper

This block sits beside an SPI shift engine and turns its single-cycle event pulses into software-visible interrupt state. Each of seven event sources sets a sticky status bit. Software clears status bits by writing ones to them. A per-source enable mask and a single global enable combine the status bits into one level-sensitive interrupt line.

The block also has a keyed soft-reset register. Writing the correct key clears every wrapper register and sends a one-cycle reset pulse to the SPI core. Writing any other value leaves all state alone and raises a sticky key error instead.

The key logic is a three-state machine:
- `RS_IDLE` is the normal state.
- `RS_PULSE` drives the core reset for one cycle.
- `RS_FAULT` holds the key error.

The transitions are:
- `T_KEY_OK`: IDLE or FAULT goes to PULSE when the correct key is written.
- `T_KEY_BAD`: IDLE or FAULT goes to FAULT when a wrong key is written.
- `T_PULSE_DONE`: PULSE always returns to IDLE.

The register bus is a simple single-cycle write strobe with address and data. Read data is a combinational decode of the current address.

Top module: `spi_irq_wrap`

## Requirements
- R1: After the hardware reset, the following are all zero: status, enable mask, global enable, `irq`, `core_rst` and `key_err`.
- R2: A one-cycle high on `evt[i]` sets status bit i, which reads at offset 0x20. The bit is set whatever the enable mask holds. The bit map is: 0 mode fault, 1 slave-mode fault, 2 TX empty, 3 TX underrun, 4 RX full, 5 RX overrun, 6 TX half empty.
- R3: A write to offset 0x20 clears exactly the status bits that are one in the written data. All other status bits keep their value.
- R4: If an event on bit i arrives in the same cycle as a clearing write to bit i, bit i ends up set.
- R5: Offset 0x28 holds the per-source enable mask in bits 6:0. It is written whole. Bits 31:7 read as zero.
- R6: Offset 0x1C holds the global enable in bit 31. Bits 30:0 read as zero.
- R7: `irq` is high exactly when the global enable is one and at least one status bit is one together with its enable bit.
- R8: Writing 0x0000000A to offset 0x40 has two effects. In the next cycle, `core_rst` goes high for exactly one cycle. In the same cycle, status, enable mask and global enable are zero.
- R9: Writing any other value to offset 0x40 changes no register and produces no `core_rst`. It sets `key_err`, which also reads as bit 0 at offset 0x40. `key_err` stays set until a correct key is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| evt | input | 7 | Event pulses from the SPI core, one per status bit |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt request |
| core_rst | output | 1 | One-cycle reset pulse to the SPI core |
| key_err | output | 1 | Sticky wrong-key indication |

## Verification
The bench sweeps every one of the 128 status patterns against every one of the 128 enable masks and checks `irq`:
- A design that used OR instead of AND between status and enable would raise `irq` for disabled sources.
- A design that ignored the global bit would fail the sweep repeated with the global enable off.

A second sweep clears all 128 masks from a fully set status. This catches a clear that drops too many bits, or one that treats the write as a plain store.

Targeted cases cover the remaining corners:
- An event colliding with its own clear; a design giving the clear priority loses the event.
- A reset pulse that lasts two cycles, or that leaves the enable mask in place.
- A wrong key that still resets the core, or that fails to latch `key_err`.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int unsigned NUM_SRC = 7;

    localparam logic [7:0] OFF_GIE    = 8'h1C;
    localparam logic [7:0] OFF_STATUS = 8'h20;
    localparam logic [7:0] OFF_ENABLE = 8'h28;
    localparam logic [7:0] OFF_SRST   = 8'h40;

    localparam logic [31:0] SRST_KEY = 32'h0000_000A;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_PULSE = 2'd1,
        RS_FAULT = 2'd2
    } rst_state_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned NSRC   = 7,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              wr_status,
    input  logic              wr_enable,
    input  logic              wr_gie,
    input  logic [DATA_W-1:0] wdata,
    output logic [NSRC-1:0]   status_o,
    output logic [NSRC-1:0]   enable_o,
    output logic              gie_o,
    output logic              irq_o
);
    localparam int unsigned GIE_BIT = DATA_W - 1;

    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] enable_q;
    logic            gie_q;

    assign clr_mask = wr_status ? wdata[NSRC-1:0] : '0;

    // One sticky flop per source: a set beats a clear, soft reset beats both.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr) begin
                bit_q <= 1'b0;
            end else if (evt_i[i]) begin
                bit_q <= 1'b1;
            end else if (clr_mask[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign status_o[i] = bit_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            enable_q <= '0;
            gie_q    <= 1'b0;
        end else begin
            if (wr_enable) begin
                enable_q <= wdata[NSRC-1:0];
            end
            if (wr_gie) begin
                gie_q <= wdata[GIE_BIT];
            end
        end
    end

    assign enable_o = enable_q;
    assign gie_o    = gie_q;
    assign irq_o    = gie_q & (|(status_o & enable_q));

    // R2 / R4: every pulsed source is set one cycle later, clear or not
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0 && !soft_clr) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    // R3: cleared bits with no colliding event read zero afterwards
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !soft_clr && ((wdata[NSRC-1:0] & ~evt_i) != '0))
        |=> ((status_o & $past(wdata[NSRC-1:0] & ~evt_i)) == '0));

    // R8: soft reset leaves no interrupt behind
    p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!irq_o && status_o == '0 && enable_o == '0 && !gie_o));
endmodule

// File: rtl/soft_reset_fsm.sv
module soft_reset_fsm
    import spi_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              key_accept_o,
    output logic              core_rst_o,
    output logic              key_err_o
);
    rst_state_e state_q, state_d;
    logic       key_match;

    assign key_match = (wdata == DATA_W'(SRST_KEY));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE, RS_FAULT: begin
                if (key_wr && key_match) begin
                    state_d = RS_PULSE;      // T_KEY_OK
                end else if (key_wr) begin
                    state_d = RS_FAULT;      // T_KEY_BAD
                end
            end
            RS_PULSE: state_d = RS_IDLE;     // T_PULSE_DONE
            default:  state_d = RS_IDLE;
        endcase
    end

    always_comb begin
        core_rst_o   = 1'b0;
        key_err_o    = 1'b0;
        key_accept_o = 1'b0;
        unique case (state_q)
            RS_IDLE:  key_accept_o = key_wr && key_match;
            RS_PULSE: core_rst_o   = 1'b1;
            RS_FAULT: begin
                key_err_o    = 1'b1;
                key_accept_o = key_wr && key_match;
            end
            default: ;
        endcase
    end

    // R8: reset pulse is a single cycle
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> !core_rst_o);

    // R8: an accepted key produces the pulse on the next cycle
    p_key_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        key_accept_o |=> core_rst_o);

    // R9: a wrong key raises the error and no pulse
    p_bad_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !key_match && !core_rst_o) |=> (key_err_o && !core_rst_o));
endmodule

// File: rtl/spi_irq_wrap.sv
module spi_irq_wrap
    import spi_irq_pkg::*;
#(
    parameter int unsigned NSRC   = NUM_SRC,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              core_rst,
    output logic              key_err
);
    localparam int unsigned GIE_BIT = DATA_W - 1;

    logic            sel_gie, sel_status, sel_enable, sel_srst;
    logic            key_accept;
    logic [NSRC-1:0] status, enable;
    logic            gie;

    assign sel_gie    = (reg_addr == ADDR_W'(OFF_GIE));
    assign sel_status = (reg_addr == ADDR_W'(OFF_STATUS));
    assign sel_enable = (reg_addr == ADDR_W'(OFF_ENABLE));
    assign sel_srst   = (reg_addr == ADDR_W'(OFF_SRST));

    soft_reset_fsm #(.DATA_W(DATA_W)) u_srst (
        .clk          (clk),
        .rst_n        (rst_n),
        .key_wr       (reg_wr && sel_srst),
        .wdata        (reg_wdata),
        .key_accept_o (key_accept),
        .core_rst_o   (core_rst),
        .key_err_o    (key_err)
    );

    irq_status_bank #(.NSRC(NSRC), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (key_accept),
        .evt_i     (evt),
        .wr_status (reg_wr && sel_status),
        .wr_enable (reg_wr && sel_enable),
        .wr_gie    (reg_wr && sel_gie),
        .wdata     (reg_wdata),
        .status_o  (status),
        .enable_o  (enable),
        .gie_o     (gie),
        .irq_o     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_gie) begin
            reg_rdata[GIE_BIT] = gie;
        end else if (sel_status) begin
            reg_rdata[NSRC-1:0] = status;
        end else if (sel_enable) begin
            reg_rdata[NSRC-1:0] = enable;
        end else if (sel_srst) begin
            reg_rdata[0] = key_err;
        end
    end

    // R7: no interrupt while the global enable is off
    p_gie_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie) |-> !irq);
endmodule

// File: tb/tb_spi_irq_wrap.sv
`timescale 1ns/1ps
module tb_spi_irq_wrap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, core_rst, key_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_irq_wrap dut (
        .clk(clk), .rst_n(rst_n), .evt(evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .core_rst(core_rst), .key_err(key_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [6:0] m);
        @(negedge clk);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h20, d); chk(d == 0, "R1 status", d, 0);
        rd(8'h28, d); chk(d == 0, "R1 enable", d, 0);
        rd(8'h1C, d); chk(d == 0, "R1 gie", d, 0);
        chk({irq, core_rst, key_err} == 3'b000, "R1 outputs", {irq, core_rst, key_err}, 0);

        // R2 latch without enable, per bit
        for (int i = 0; i < 7; i++) begin
            wr(8'h20, 32'h7F);
            pulse(7'(1 << i));
            rd(8'h20, d); chk(d == (32'd1 << i), "R2 single source", d, 32'd1 << i);
            chk(irq == 1'b0, "R2 no irq when disabled", irq, 0);
        end

        // R5 / R6 field widths
        wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, d); chk(d == 32'h7F, "R5 enable width", d, 32'h7F);
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, d); chk(d == 32'h8000_0000, "R6 gie bit31", d, 32'h8000_0000);
        wr(8'h1C, 32'h7FFF_FFFF); rd(8'h1C, d); chk(d == 0, "R6 gie other bits", d, 0);

        // R7 exhaustive status x enable sweep
        for (int s = 0; s < 128; s++) begin
            wr(8'h20, 32'h7F);
            pulse(7'(s));
            rd(8'h20, d); chk(d == 32'(s), "R2 pattern", d, 32'(s));
            wr(8'h1C, 32'h0);
            wr(8'h28, 32'h7F);
            chk(irq == 1'b0, "R7 gie off", irq, 0);
            wr(8'h1C, 32'h8000_0000);
            for (int e = 0; e < 128; e++) begin
                wr(8'h28, 32'(e));
                chk(irq == ((s & e) != 0), "R7 irq", irq, 32'((s & e) != 0));
            end
        end

        // R3 write-one-to-clear sweep
        for (int c = 0; c < 128; c++) begin
            pulse(7'h7F);
            wr(8'h20, 32'(c));
            rd(8'h20, d); chk(d == 32'(7'h7F & ~7'(c)), "R3 w1c", d, 32'(7'h7F & ~7'(c)));
        end

        // R4 set beats clear on the same bit
        wr(8'h20, 32'h7F);
        pulse(7'h09);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h0B; evt = 7'h02;
        @(negedge clk);
        reg_wr = 1'b0; evt = '0;
        rd(8'h20, d); chk(d == 32'h02, "R4 set priority", d, 32'h02);

        // R9 wrong key
        wr(8'h28, 32'h12);
        wr(8'h1C, 32'h8000_0000);
        pulse(7'h10);
        wr(8'h40, 32'h0B);
        chk(key_err == 1'b1, "R9 key_err set", key_err, 1);
        chk(core_rst == 1'b0, "R9 no pulse", core_rst, 0);
        rd(8'h28, d); chk(d == 32'h12, "R9 enable kept", d, 32'h12);
        rd(8'h20, d); chk(d == 32'h12, "R9 status kept", d, 32'h12);
        rd(8'h40, d); chk(d == 32'h1, "R9 readback", d, 1);
        @(negedge clk);
        chk(key_err == 1'b1 && core_rst == 1'b0, "R9 sticky", {key_err, core_rst}, 2'b10);
        wr(8'h40, 32'h0000_010A);
        chk(core_rst == 1'b0, "R9 near-miss key", core_rst, 0);

        // R8 correct key
        chk(irq == 1'b1, "R8 irq before reset", irq, 1);
        wr(8'h40, 32'h0A);
        chk(core_rst == 1'b1, "R8 pulse high", core_rst, 1);
        rd(8'h20, d); chk(d == 0, "R8 status cleared", d, 0);
        rd(8'h28, d); chk(d == 0, "R8 enable cleared", d, 0);
        rd(8'h1C, d); chk(d == 0, "R8 gie cleared", d, 0);
        chk(irq == 1'b0, "R8 irq low", irq, 0);
        @(negedge clk);
        chk(core_rst == 1'b0, "R8 pulse one cycle", core_rst, 0);
        chk(key_err == 1'b0, "R9 error cleared by good key", key_err, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule